// File: doc/BRIEF.md
# Four-Channel Converter Code Register Bank

This block is the digital front end of a four-channel, 12-bit voltage-output converter. A shared parallel bus word feeds four code registers, one per converter. Each register has its own active-low select: while the select is low the register follows the bus, and while it is high the register keeps its last value. The selects are independent and level-sensitive, so any subset of channels can load the same word together. A select that is held low keeps its channel transparent.

Selects come from two sources, which are ANDed per channel. The first is a direct select input. The second is a small bus-side decoder that combines a write strobe with a base-address match and then uses the low word-address bits, one bit per channel, so that one write can reach several channels. The 12-bit code is taken from either the upper or the lower 12 bits of a 16-bit bus word. Codes are offset binary: 0x800 is mid-scale (zero output), 0xFFF is one LSB below positive full scale, and 0x000 is negative full scale.

A timing monitor on each channel checks every select pulse at its rising edge. It flags a pulse that was low for fewer than `MIN_PW` clock edges, or a code that was not stable for at least `MIN_SETUP` edges before the rise. Each violation flag is sticky until reset.

Top module: `qdac_bank`

## Requirements
- R1: A synchronous reset loads 0x800 (mid-scale, zero output) into all four code registers and clears every violation flag.
- R2: When the effective select of a channel is low at a clock edge, that channel's register takes the bus code at that edge, visible one clock later. When the select is high, the register holds its value.
- R3: Any mix of the four selects may be low at the same edge. All four low loads every channel with the same code. All four high leaves every channel unchanged, whatever the bus does.
- R4: A select held low over many edges keeps its register transparent, following every new bus code with one clock of latency.
- R5: The decoded select of channel i is active only when `wr_strobe`=1, `base_match`=1 and `word_addr[i]`=0. Several zero address bits select several channels. Without the strobe or the base match, no channel loads.
- R6: With `left_just`=1 the code is `bus_word[15:4]`; with `left_just`=0 it is `bus_word[11:0]`, and bits 15:12 are ignored.
- R7: If a channel's select was low for fewer than `MIN_PW` consecutive edges before it rises, `width_err[i]` is set at the rise edge and stays set until reset.
- R8: If the code sampled at the edges before a channel's select rises was constant for fewer than `MIN_SETUP` consecutive edges (counting the last low edge), `setup_err[i]` is set at the rise edge and stays set until reset.
- R9: A pulse that meets both minimums sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_word | input | 16 | Shared data bus word |
| left_just | input | 1 | 1: code in bits 15:4, 0: code in bits 11:0 |
| ext_sel_n | input | 4 | Direct active-low channel selects |
| wr_strobe | input | 1 | Bus write strobe for the decoder |
| base_match | input | 1 | Base-address match for the decoder |
| word_addr | input | 4 | Word-address bits, bit i low selects channel i |
| dac_code | output | 48 | Channel codes, channel i at bits 12i+11:12i |
| width_err | output | 4 | Sticky short-pulse flag per channel |
| setup_err | output | 4 | Sticky short-setup flag per channel |

## Verification
A code loaded at a clock edge appears on `dac_code` right after that edge. The bench therefore changes its inputs on falling edges, queues the expected codes at the falling edge after the last low edge of a pulse, and compares them one nanosecond later. Violation flags are set at the rise edge, one clock after the pulse's last low edge, so flag checks wait one more falling edge after the select is raised. The transparent-mode check updates the bus on each falling edge and expects the previous value in the current cycle.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int N_CH   = 4;
    localparam int CODE_W = 12;
    localparam int BUS_W  = 16;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t MID_CODE = code_t'(1) << (CODE_W - 1);

    // select the code field from a bus word
    function automatic code_t pick_code(logic [BUS_W-1:0] w, logic left);
        return left ? w[BUS_W-1 -: CODE_W] : w[CODE_W-1:0];
    endfunction
endpackage

// File: rtl/qdac_bus_decoder.sv
module qdac_bus_decoder #(
    parameter int NCH = qdac_pkg::N_CH
) (
    input  logic           wr_strobe,
    input  logic           base_match,
    input  logic [NCH-1:0] word_addr,
    output logic [NCH-1:0] sel_n
);
    logic gate;
    assign gate  = wr_strobe & base_match;
    assign sel_n = ~({NCH{gate}} & ~word_addr);
endmodule

// File: rtl/qdac_chan_reg.sv
module qdac_chan_reg
    import qdac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_n,
    input  code_t d,
    output code_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= MID_CODE;
        else if (!sel_n)
            q <= d;
    end
endmodule

// File: rtl/qdac_timing_mon.sv
module qdac_timing_mon
    import qdac_pkg::*;
#(
    parameter int MIN_PW    = 3,
    parameter int MIN_SETUP = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_n,
    input  code_t code,
    output logic  width_err,
    output logic  setup_err
);
    localparam int LIM   = (MIN_PW > MIN_SETUP) ? MIN_PW : MIN_SETUP;
    localparam int CNT_W = $clog2(LIM + 1) + 1;
    typedef logic [CNT_W-1:0] cnt_t;

    cnt_t  low_cnt, stab_cnt;
    logic  was_low;
    code_t last_code;

    function automatic cnt_t sat_inc(cnt_t c);
        return (c == '1) ? c : c + cnt_t'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= '0;
            stab_cnt  <= '0;
            was_low   <= 1'b0;
            last_code <= MID_CODE;
            width_err <= 1'b0;
            setup_err <= 1'b0;
        end else begin
            was_low   <= !sel_n;
            low_cnt   <= sel_n ? '0 : sat_inc(low_cnt);
            stab_cnt  <= (code == last_code) ? sat_inc(stab_cnt) : cnt_t'(1);
            last_code <= code;
            if (sel_n && was_low) begin
                if (low_cnt < cnt_t'(MIN_PW))
                    width_err <= 1'b1;
                if (stab_cnt < cnt_t'(MIN_SETUP))
                    setup_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
    import qdac_pkg::*;
#(
    parameter int NCH       = N_CH,
    parameter int MIN_PW    = 3,
    parameter int MIN_SETUP = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BUS_W-1:0]      bus_word,
    input  logic                  left_just,
    input  logic [NCH-1:0]        ext_sel_n,
    input  logic                  wr_strobe,
    input  logic                  base_match,
    input  logic [NCH-1:0]        word_addr,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic [NCH-1:0]        width_err,
    output logic [NCH-1:0]        setup_err
);
    code_t          bus_code;
    logic [NCH-1:0] dec_sel_n;
    logic [NCH-1:0] eff_sel_n;

    assign bus_code = pick_code(bus_word, left_just);

    qdac_bus_decoder #(.NCH(NCH)) u_dec (
        .wr_strobe  (wr_strobe),
        .base_match (base_match),
        .word_addr  (word_addr),
        .sel_n      (dec_sel_n)
    );

    assign eff_sel_n = ext_sel_n & dec_sel_n;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        qdac_chan_reg u_reg (
            .clk   (clk),
            .rst   (rst),
            .sel_n (eff_sel_n[i]),
            .d     (bus_code),
            .q     (dac_code[i*CODE_W +: CODE_W])
        );
        qdac_timing_mon #(.MIN_PW(MIN_PW), .MIN_SETUP(MIN_SETUP)) u_mon (
            .clk       (clk),
            .rst       (rst),
            .sel_n     (eff_sel_n[i]),
            .code      (bus_code),
            .width_err (width_err[i]),
            .setup_err (setup_err[i])
        );
    end
endmodule

// File: rtl/qdac_bank_chk.sv
module qdac_bank_chk
    import qdac_pkg::*;
#(
    parameter int NCH = N_CH
) (
    input logic                  clk,
    input logic                  rst,
    input logic [BUS_W-1:0]      bus_word,
    input logic                  left_just,
    input logic [NCH-1:0]        ext_sel_n,
    input logic                  wr_strobe,
    input logic                  base_match,
    input logic [NCH-1:0]        word_addr,
    input logic [NCH*CODE_W-1:0] dac_code,
    input logic [NCH-1:0]        width_err,
    input logic [NCH-1:0]        setup_err
);
    // R1
    reset_mid_chk: assert property (@(posedge clk)
        $past(rst) && !rst |-> dac_code == {NCH{MID_CODE}} && width_err == '0 && setup_err == '0);

    // R3
    all_latched_chk: assert property (@(posedge clk) disable iff (rst)
        (&ext_sel_n && !wr_strobe) |=> $stable(dac_code));

    // R5
    no_base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (&ext_sel_n && !base_match) |=> $stable(dac_code));

    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R2
        load_follow_chk: assert property (@(posedge clk) disable iff (rst)
            !ext_sel_n[i] |=> dac_code[i*CODE_W +: CODE_W] == $past(pick_code(bus_word, left_just)));

        // R7
        width_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            width_err[i] |=> width_err[i]);

        // R8
        setup_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            setup_err[i] |=> setup_err[i]);
    end
endmodule

bind qdac_bank qdac_bank_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_word   (bus_word),
    .left_just  (left_just),
    .ext_sel_n  (ext_sel_n),
    .wr_strobe  (wr_strobe),
    .base_match (base_match),
    .word_addr  (word_addr),
    .dac_code   (dac_code),
    .width_err  (width_err),
    .setup_err  (setup_err)
);

// File: tb/qdac_bank_test.sv
module qdac_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_word = 16'h0000;
    logic        left_just = 1'b0;
    logic [3:0]  ext_sel_n = 4'hF;
    logic        wr_strobe = 1'b0;
    logic        base_match = 1'b0;
    logic [3:0]  word_addr = 4'hF;
    logic [47:0] dac_code;
    logic [3:0]  width_err, setup_err;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string      req;
        int         ch;
        logic [11:0] val;
    } exp_t;
    exp_t exp_q[$];
    logic [11:0] m [4];

    always #2 clk = ~clk;

    qdac_bank uut (
        .clk(clk), .rst(rst), .bus_word(bus_word), .left_just(left_just),
        .ext_sel_n(ext_sel_n), .wr_strobe(wr_strobe), .base_match(base_match),
        .word_addr(word_addr), .dac_code(dac_code),
        .width_err(width_err), .setup_err(setup_err)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: queue the model's expected codes
    task automatic expect_all(string req);
        for (int c = 0; c < 4; c++) begin
            exp_t e;
            e.req = req; e.ch = c; e.val = m[c];
            exp_q.push_back(e);
        end
    endtask

    task automatic chk_flags(string req, logic [3:0] ew, logic [3:0] es);
        #1;
        checks++;
        if (width_err !== ew || setup_err !== es) begin
            errors++;
            $display("FAIL %s flags: width=%b setup=%b expected width=%b setup=%b",
                     req, width_err, setup_err, ew, es);
        end
    endtask

    // monitor: compare queued expectations just after each falling edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (dac_code[e.ch*12 +: 12] !== e.val) begin
                    errors++;
                    $display("FAIL %s ch%0d: got %h expected %h",
                             e.req, e.ch, dac_code[e.ch*12 +: 12], e.val);
                end
            end
        end
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) m[c] = 12'h800;
        tick(2);
        rst = 1'b0;
        tick(1);
        expect_all("R1");
        chk_flags("R1", 4'b0000, 4'b0000);

        // R2 / R6: right-justified, upper bits ignored, channel 0 only
        bus_word = 16'hFABC; left_just = 1'b0; ext_sel_n = 4'b1110;
        tick(3);
        ext_sel_n = 4'hF; m[0] = 12'hABC;
        expect_all("R2");
        bus_word = 16'h0123;
        tick(2);
        expect_all("R2");
        chk_flags("R9", 4'b0000, 4'b0000);

        // R6 left-justified, R3 two channels together
        bus_word = 16'hFFF0; left_just = 1'b1; ext_sel_n = 4'b1001;
        tick(3);
        ext_sel_n = 4'hF; m[1] = 12'hFFF; m[2] = 12'hFFF;
        expect_all("R6");
        tick(1);
        chk_flags("R9", 4'b0000, 4'b0000);

        // R3 all four together, then all latched
        bus_word = 16'h0000; left_just = 1'b0; ext_sel_n = 4'b0000;
        tick(3);
        ext_sel_n = 4'hF;
        for (int c = 0; c < 4; c++) m[c] = 12'h000;
        expect_all("R3");
        bus_word = 16'h0FFF;
        tick(3);
        expect_all("R3");

        // R4 transparent channel 3
        ext_sel_n = 4'b0111; bus_word = 16'h0111;
        tick(1);
        m[3] = 12'h111; expect_all("R4");
        bus_word = 16'h0222;
        tick(1);
        m[3] = 12'h222; expect_all("R4");
        bus_word = 16'h0333;
        tick(3);
        m[3] = 12'h333; expect_all("R4");
        ext_sel_n = 4'hF;
        tick(2);
        chk_flags("R9", 4'b0000, 4'b0000);

        // R5 decoder: address 1010 selects channels 0 and 2
        wr_strobe = 1'b1; base_match = 1'b1; word_addr = 4'b1010; bus_word = 16'h05A5;
        tick(3);
        wr_strobe = 1'b0; m[0] = 12'h5A5; m[2] = 12'h5A5;
        expect_all("R5");
        wr_strobe = 1'b1; base_match = 1'b0; word_addr = 4'b0000; bus_word = 16'h0777;
        tick(3);
        expect_all("R5");
        wr_strobe = 1'b0; base_match = 1'b1;
        tick(3);
        expect_all("R5");
        base_match = 1'b0;
        tick(1);
        chk_flags("R5", 4'b0000, 4'b0000);

        // R7 one-edge pulse on channel 1, then a good pulse keeps the flag
        bus_word = 16'h0444;
        tick(3);
        ext_sel_n = 4'b1101;
        tick(1);
        ext_sel_n = 4'hF; m[1] = 12'h444;
        expect_all("R7");
        tick(1);
        chk_flags("R7", 4'b0010, 4'b0000);
        ext_sel_n = 4'b1101;
        tick(3);
        ext_sel_n = 4'hF;
        tick(2);
        expect_all("R7");
        chk_flags("R7", 4'b0010, 4'b0000);

        // R8 data changes on the last low edge of channel 2
        ext_sel_n = 4'b1011; bus_word = 16'h0100;
        tick(2);
        bus_word = 16'h0200;
        tick(1);
        ext_sel_n = 4'hF; m[2] = 12'h200;
        expect_all("R8");
        tick(1);
        chk_flags("R8", 4'b0010, 4'b0100);

        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule